// File: doc/BRIEF.md
# Lightweight Authenticated Encryption Core

This block encrypts one fixed-shape message and authenticates it. The message is a short associated-data field and a 31-byte plaintext. The state is 320 bits, held as five 64-bit words. The first word is the rate lane, and the other four form the hidden capacity. A round-based permutation updates the state once per clock. It runs a long 12-round pass around the setup and tag phases, and short 6-round passes between data blocks. The key and the nonce are each 128 bits.

A host pulses `start` with the key, the nonce and the associated data. The core then raises `pt_req` whenever it can accept the next 64-bit plaintext block. Each accepted block returns one ciphertext word with a byte-keep mask. After the final partial block, the core runs the closing permutation and presents a 128-bit tag with `done`. The tag and `done` hold until the next start.

All byte strings are big-endian in a word: the first byte sits in bits 63:56.

Top module: `aead_core`

## Requirements
- R1: During reset and in the cycle after it is released, `done`, `ct_valid` and `pt_req` are 0.
- R2: `pt_req` first goes high exactly 18 clocks after the edge that accepts `start`. This covers 12 setup rounds and 6 associated-data rounds.
- R3: Each ciphertext word equals the rate word after the plaintext block has been XORed into it. The state is seeded as follows: word 0 holds the constant 0x80400C0600000000, words 1-2 hold the key, and words 3-4 hold the nonce. The setup permutation is followed by a key XOR into words 3-4. After the associated data, a 1 is XORed into bit 0 of word 4. A 6-round pass separates successive full blocks.
- R4: The associated data (4 bytes by default) is padded inside the core with one 0x80 byte and then zeros, and absorbed into word 0 before a 6-round pass.
- R5: `ct_valid` is a one-cycle pulse in the cycle after a block is accepted (`pt_valid` and `pt_req` both high at an edge). `pt_req` drops then and returns 6 clocks later for every block but the last.
- R6: For the fourth block, the core uses only bits 63:8 of `pt_data` and inserts the padding byte 0x80 at bits 7:0. `ct_keep` is 8'hFE, where bit k covers `ct_data[8k+7:8k]`. Bits 7:0 of `ct_data` read 0. Full blocks give `ct_keep` = 8'hFF.
- R7: `done` rises exactly 12 clocks after the last block is accepted. The tag is formed from words 3-4 XOR the key, after the key has been XORed into words 1-2 and 12 rounds have run. The tag and `done` hold until the next `start`.
- R8: The core captures the key and the associated data at `start`. Later changes to those inputs, or a `start` while busy, have no effect on the ciphertext or the tag.
- R9: `pt_valid` is ignored whenever `pt_req` is low, and `pt_req` stays high until a block is accepted.
- R10: Take the key 00 01 .. 0F, the nonce 00 11 .. FF, the associated data 32 30 32 33 and the 31-byte text "Concevez ASCON en SystemVerilog". With these inputs the ciphertext words are 0567b46d138a8b5f, db5cba9823530f3f and 3339ce01a4e4b32f, then 1fc9a149abfd3a with the last byte dropped. The tag is C5EB902A13307077470039BC3A6928EC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new message (accepted only when idle) |
| key | input | 128 | Secret key, captured at start |
| nonce | input | 128 | Per-message nonce, used at start |
| ad_data | input | 8*AD_BYTES | Associated data bytes, captured at start |
| pt_valid | input | 1 | Plaintext block offered |
| pt_data | input | 64 | Plaintext block, first byte in bits 63:56 |
| pt_req | output | 1 | Core is waiting for the next plaintext block |
| ct_valid | output | 1 | Ciphertext word valid (one cycle) |
| ct_data | output | 64 | Ciphertext word |
| ct_keep | output | 8 | Valid bytes of ct_data, bit k for byte bits 8k+7:8k |
| tag | output | 128 | Authentication tag |
| done | output | 1 | Tag valid, held until next start |

## Verification
The properties assume that `pt_valid` is only meaningful while `pt_req` is high, and that `start` is the only event that clears a finished result. They place no limit on when a host may toggle either input. The stimulus therefore sprays random `start` and `pt_valid` pulses and junk `pt_data` into every busy phase. It also changes the key and the associated data right after start and inserts random gaps before blocks are offered. The known-answer vector and random messages are checked against a bench model that uses a table-driven S-box.

// File: rtl/aead_core_pkg.sv
// Shared types and constants for the authenticated encryption core.
// Assumes a 320-bit state split into five 64-bit words, word 0 = rate lane.
package aead_core_pkg;
    typedef logic [63:0]       word_t;
    typedef logic [4:0][63:0]  state_t;

    localparam word_t INIT_VECTOR = 64'h80400C0600000000;

    localparam int FULL_ROUNDS = 12;
    localparam int HALF_ROUNDS = 6;
    localparam logic [3:0] LAST_RIDX  = 4'(FULL_ROUNDS - 1);
    localparam logic [3:0] HALF_START = 4'(FULL_ROUNDS - HALF_ROUNDS);

    // Right-rotate pairs of the linear layer, one pair per state word.
    localparam int ROT_A [5] = '{19, 61, 1, 10, 7};
    localparam int ROT_B [5] = '{28, 39, 6, 17, 41};

    typedef enum logic [2:0] {
        PH_IDLE, PH_INIT, PH_AD, PH_WAIT, PH_MSG, PH_FIN
    } phase_t;
endpackage

// File: rtl/aead_round.sv
// One permutation round, purely combinational.
// Applies the round constant to word 2, the bitsliced 5-bit S-box and the
// per-word rotate-XOR diffusion. Assumes ridx is in 0..11.
module aead_round
    import aead_core_pkg::*;
(
    input  state_t      s_in,
    input  logic [3:0]  ridx,
    output state_t      s_out
);
    word_t c2;
    word_t a0, a1, a2, a3, a4;
    word_t b0, b1, b2, b3, b4;
    state_t mixed;

    // Round constant: high nibble is 15 - ridx, low nibble is ridx.
    assign c2 = s_in[2] ^ {56'd0, ~ridx, ridx};

    // S-box input mixing.
    assign a0 = s_in[0] ^ s_in[4];
    assign a1 = s_in[1];
    assign a2 = c2 ^ s_in[1];
    assign a3 = s_in[3];
    assign a4 = s_in[4] ^ s_in[3];

    // Nonlinear chi-like step.
    assign b0 = a0 ^ (~a1 & a2);
    assign b1 = a1 ^ (~a2 & a3);
    assign b2 = a2 ^ (~a3 & a4);
    assign b3 = a3 ^ (~a4 & a0);
    assign b4 = a4 ^ (~a0 & a1);

    // S-box output mixing.
    assign mixed[0] = b0 ^ b4;
    assign mixed[1] = b1 ^ b0;
    assign mixed[2] = ~b2;
    assign mixed[3] = b3 ^ b2;
    assign mixed[4] = b4;

    // Linear layer: each word XORed with two rotations of itself.
    for (genvar i = 0; i < 5; i++) begin : g_lin
        localparam int RA = ROT_A[i];
        localparam int RB = ROT_B[i];
        assign s_out[i] = mixed[i]
                        ^ {mixed[i][RA-1:0], mixed[i][63:RA]}
                        ^ {mixed[i][RB-1:0], mixed[i][63:RB]};
    end
endmodule

// File: rtl/aead_ctrl.sv
// Sequencer for the encryption core.
// Walks setup, associated data, block wait, inter-block rounds and tag
// rounds. One 4-bit counter indexes rounds; long passes start at 0 and
// short passes start at 6, so every pass ends at index 11.
// Assumes NBLK >= 1.
module aead_ctrl
    import aead_core_pkg::*;
#(
    parameter int NBLK = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        pt_valid,
    output phase_t      phase,
    output logic [3:0]  ridx,
    output logic        load_go,
    output logic        round_en,
    output logic        round_last,
    output logic        absorb,
    output logic        absorb_last
);
    localparam int BLK_W = (NBLK > 1) ? $clog2(NBLK) : 1;
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NBLK - 1);

    logic [BLK_W-1:0] blk;

    // Decode strobes for the datapath from phase and counters.
    always_comb begin
        load_go     = (phase == PH_IDLE) && start;
        round_en    = (phase == PH_INIT) || (phase == PH_AD) ||
                      (phase == PH_MSG)  || (phase == PH_FIN);
        round_last  = round_en && (ridx == LAST_RIDX);
        absorb      = (phase == PH_WAIT) && pt_valid;
        absorb_last = absorb && (blk == LAST_BLK);
    end

    // Phase, round index and block index sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            ridx  <= '0;
            blk   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_INIT;
                    ridx  <= '0;
                end
                PH_INIT: if (round_last) begin
                    phase <= PH_AD;
                    ridx  <= HALF_START;
                end else begin
                    ridx  <= ridx + 4'd1;
                end
                PH_AD: if (round_last) begin
                    phase <= PH_WAIT;
                    blk   <= '0;
                end else begin
                    ridx  <= ridx + 4'd1;
                end
                PH_WAIT: if (pt_valid) begin
                    if (blk == LAST_BLK) begin
                        phase <= PH_FIN;
                        ridx  <= '0;
                    end else begin
                        phase <= PH_MSG;
                        ridx  <= HALF_START;
                        blk   <= blk + 1'b1;
                    end
                end
                PH_MSG: if (round_last) begin
                    phase <= PH_WAIT;
                end else begin
                    ridx  <= ridx + 4'd1;
                end
                PH_FIN: if (round_last) begin
                    phase <= PH_IDLE;
                end else begin
                    ridx  <= ridx + 4'd1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/aead_state.sv
// State register with key, data and padding injection.
// Injections that follow a permutation are folded into its last round
// edge; the final-block absorb also applies the pre-tag key XOR.
// Assumes 1 <= AD_BYTES <= 7 and 1 <= LAST_BYTES <= 7.
module aead_state
    import aead_core_pkg::*;
#(
    parameter int AD_BYTES   = 4,
    parameter int LAST_BYTES = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_go,
    input  logic               round_en,
    input  logic               round_last,
    input  logic               absorb,
    input  logic               absorb_last,
    input  phase_t             phase,
    input  logic [3:0]         ridx,
    input  logic [127:0]       key,
    input  logic [127:0]       nonce,
    input  logic [8*AD_BYTES-1:0] ad_data,
    input  word_t              pt_data,
    output word_t              ct_word,
    output logic [127:0]       tag_word
);
    localparam int    AD_W      = 8 * AD_BYTES;
    localparam word_t TAIL_MASK = ~(64'hFFFF_FFFF_FFFF_FFFF >> (8 * LAST_BYTES));
    localparam word_t TAIL_PAD  = 64'h80 << (56 - 8 * LAST_BYTES);
    localparam word_t AD_MARK   = 64'h80 << (56 - AD_W);

    state_t          st_q, st_d, st_rnd;
    logic [127:0]    key_q;
    logic [AD_W-1:0] ad_q;
    word_t           ad_pad, pt_in, ct_q;
    logic [127:0]    tag_q;

    aead_round u_round (
        .s_in  (st_q),
        .ridx  (ridx),
        .s_out (st_rnd)
    );

    // Padded associated data and the plaintext as it enters the rate lane.
    always_comb begin
        ad_pad = (64'(ad_q) << (64 - AD_W)) | AD_MARK;
        pt_in  = absorb_last ? ((pt_data & TAIL_MASK) | TAIL_PAD) : pt_data;
    end

    // Next-state selection: load, round with trailing injections, or absorb.
    always_comb begin
        st_d = st_q;
        if (load_go) begin
            st_d[0] = INIT_VECTOR;
            st_d[1] = key[127:64];
            st_d[2] = key[63:0];
            st_d[3] = nonce[127:64];
            st_d[4] = nonce[63:0];
        end else if (round_en) begin
            st_d = st_rnd;
            if (round_last && phase == PH_INIT) begin
                st_d[3] = st_rnd[3] ^ key_q[127:64];
                st_d[4] = st_rnd[4] ^ key_q[63:0];
                st_d[0] = st_rnd[0] ^ ad_pad;
            end else if (round_last && phase == PH_AD) begin
                st_d[4] = st_rnd[4] ^ 64'd1;
            end
        end else if (absorb) begin
            st_d[0] = st_q[0] ^ pt_in;
            if (absorb_last) begin
                st_d[1] = st_q[1] ^ key_q[127:64];
                st_d[2] = st_q[2] ^ key_q[63:0];
            end
        end
    end

    // State, captured inputs, ciphertext word and tag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            key_q <= '0;
            ad_q  <= '0;
            ct_q  <= '0;
            tag_q <= '0;
        end else begin
            st_q <= st_d;
            if (load_go) begin
                key_q <= key;
                ad_q  <= ad_data;
            end
            if (absorb) begin
                ct_q <= (st_q[0] ^ pt_in) & (absorb_last ? TAIL_MASK : '1);
            end
            if (round_last && phase == PH_FIN) begin
                tag_q <= {st_rnd[3] ^ key_q[127:64], st_rnd[4] ^ key_q[63:0]};
            end
        end
    end

    assign ct_word  = ct_q;
    assign tag_word = tag_q;
endmodule

// File: rtl/aead_core.sv
// Top of the authenticated encryption core.
// Joins the sequencer and the state datapath and registers the output
// strobes. Assumes PT_BYTES is not a multiple of 8 (the last block is partial).
module aead_core
    import aead_core_pkg::*;
#(
    parameter int AD_BYTES = 4,
    parameter int PT_BYTES = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [127:0]          key,
    input  logic [127:0]          nonce,
    input  logic [8*AD_BYTES-1:0] ad_data,
    input  logic                  pt_valid,
    input  logic [63:0]           pt_data,
    output logic                  pt_req,
    output logic                  ct_valid,
    output logic [63:0]           ct_data,
    output logic [7:0]            ct_keep,
    output logic [127:0]          tag,
    output logic                  done
);
    localparam int NBLK       = (PT_BYTES + 7) / 8;
    localparam int LAST_BYTES = PT_BYTES - 8 * (NBLK - 1);
    localparam logic [7:0] LAST_KEEP = 8'(8'hFF << (8 - LAST_BYTES));

    phase_t     phase;
    logic [3:0] ridx;
    logic       load_go, round_en, round_last, absorb, absorb_last;

    aead_ctrl #(.NBLK(NBLK)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pt_valid    (pt_valid),
        .phase       (phase),
        .ridx        (ridx),
        .load_go     (load_go),
        .round_en    (round_en),
        .round_last  (round_last),
        .absorb      (absorb),
        .absorb_last (absorb_last)
    );

    aead_state #(.AD_BYTES(AD_BYTES), .LAST_BYTES(LAST_BYTES)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_go     (load_go),
        .round_en    (round_en),
        .round_last  (round_last),
        .absorb      (absorb),
        .absorb_last (absorb_last),
        .phase       (phase),
        .ridx        (ridx),
        .key         (key),
        .nonce       (nonce),
        .ad_data     (ad_data),
        .pt_data     (pt_data),
        .ct_word     (ct_data),
        .tag_word    (tag)
    );

    assign pt_req = (phase == PH_WAIT);

    // Output strobes: ciphertext valid and keep, and the sticky done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ct_valid <= 1'b0;
            ct_keep  <= '0;
            done     <= 1'b0;
        end else begin
            ct_valid <= absorb;
            if (absorb) begin
                ct_keep <= absorb_last ? LAST_KEEP : 8'hFF;
            end
            if (load_go) begin
                done <= 1'b0;
            end else if (round_last && phase == PH_FIN) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/aead_core_chk.sv
// Handshake and result-holding properties for aead_core, attached by bind.
// Assumes a synchronous active-low reset held from time zero.
module aead_core_chk #(
    parameter int PT_BYTES = 31
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         pt_valid,
    input logic         pt_req,
    input logic         ct_valid,
    input logic [7:0]   ct_keep,
    input logic [127:0] tag,
    input logic         done
);
    localparam int NBLK       = (PT_BYTES + 7) / 8;
    localparam int LAST_BYTES = PT_BYTES - 8 * (NBLK - 1);
    localparam logic [7:0] LAST_KEEP = 8'(8'hFF << (8 - LAST_BYTES));

    a_r5_ct_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> $past(pt_req && pt_valid));

    a_r5_ct_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |=> !ct_valid);

    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && pt_valid) |=> !pt_req);

    a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && !pt_valid) |=> pt_req);

    a_r8_start_ignored_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_req && start && !pt_valid) |=> (pt_req && !done));

    a_r6_keep_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ct_valid |-> (ct_keep == 8'hFF || ct_keep == LAST_KEEP));

    a_r7_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(tag)));

    a_r7_done_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pt_req);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!done && !ct_valid && !pt_req));
endmodule

bind aead_core aead_core_chk #(.PT_BYTES(PT_BYTES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pt_valid (pt_valid),
    .pt_req   (pt_req),
    .ct_valid (ct_valid),
    .ct_keep  (ct_keep),
    .tag      (tag),
    .done     (done)
);

// File: tb/sim_aead_core.sv
// Self-checking bench for aead_core: a known-answer vector plus seeded
// random messages, with junk handshake traffic injected into busy phases.
module sim_aead_core;
    localparam int AD_BYTES = 4;
    localparam int PT_BYTES = 31;
    localparam int NBLK     = 4;
    localparam logic [63:0] TAIL_MASK = 64'hFFFF_FFFF_FFFF_FF00;
    localparam logic [7:0]  TAIL_KEEP = 8'hFE;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key = '0;
    logic [127:0] nonce = '0;
    logic [31:0]  ad_data = '0;
    logic         pt_valid = 1'b0;
    logic [63:0]  pt_data = '0;
    logic         pt_req, ct_valid, done;
    logic [63:0]  ct_data;
    logic [7:0]   ct_keep;
    logic [127:0] tag;

    int checks = 0;
    int errors = 0;
    logic [63:0]  got_ct [NBLK];
    logic [127:0] got_tag;

    aead_core #(.AD_BYTES(AD_BYTES), .PT_BYTES(PT_BYTES)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .nonce(nonce),
        .ad_data(ad_data), .pt_valid(pt_valid), .pt_data(pt_data),
        .pt_req(pt_req), .ct_valid(ct_valid), .ct_data(ct_data),
        .ct_keep(ct_keep), .tag(tag), .done(done)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference S-box as a lookup table, word 0 bit is the index MSB.
    function automatic logic [4:0] sbox5(input logic [4:0] i);
        case (i)
            5'd0: return 5'h04;  5'd1: return 5'h0b;  5'd2: return 5'h1f;  5'd3: return 5'h14;
            5'd4: return 5'h1a;  5'd5: return 5'h15;  5'd6: return 5'h09;  5'd7: return 5'h02;
            5'd8: return 5'h1b;  5'd9: return 5'h05;  5'd10: return 5'h08; 5'd11: return 5'h12;
            5'd12: return 5'h1d; 5'd13: return 5'h03; 5'd14: return 5'h06; 5'd15: return 5'h1c;
            5'd16: return 5'h1e; 5'd17: return 5'h13; 5'd18: return 5'h07; 5'd19: return 5'h0e;
            5'd20: return 5'h00; 5'd21: return 5'h0d; 5'd22: return 5'h11; 5'd23: return 5'h18;
            5'd24: return 5'h10; 5'd25: return 5'h0c; 5'd26: return 5'h01; 5'd27: return 5'h19;
            5'd28: return 5'h16; 5'd29: return 5'h0a; 5'd30: return 5'h0f; default: return 5'h17;
        endcase
    endfunction

    function automatic logic [63:0] rotr(input logic [63:0] w, input int n);
        return (w >> n) | (w << (64 - n));
    endfunction

    function automatic logic [4:0][63:0] perm(input logic [4:0][63:0] st, input int nr);
        for (int r = 12 - nr; r < 12; r++) begin
            st[2] = st[2] ^ 64'((15 - r) * 16 + r);
            for (int b = 0; b < 64; b++) begin
                logic [4:0] o;
                o = sbox5({st[0][b], st[1][b], st[2][b], st[3][b], st[4][b]});
                st[0][b] = o[4]; st[1][b] = o[3]; st[2][b] = o[2];
                st[3][b] = o[1]; st[4][b] = o[0];
            end
            st[0] = st[0] ^ rotr(st[0], 19) ^ rotr(st[0], 28);
            st[1] = st[1] ^ rotr(st[1], 61) ^ rotr(st[1], 39);
            st[2] = st[2] ^ rotr(st[2], 1)  ^ rotr(st[2], 6);
            st[3] = st[3] ^ rotr(st[3], 10) ^ rotr(st[3], 17);
            st[4] = st[4] ^ rotr(st[4], 7)  ^ rotr(st[4], 41);
        end
        return st;
    endfunction

    // Bench model of the whole message; block 0 sits in p[255:192].
    task automatic model(input logic [127:0] k, input logic [127:0] n,
                         input logic [31:0] a, input logic [255:0] p,
                         output logic [255:0] c, output logic [127:0] t);
        logic [4:0][63:0] st;
        logic [63:0] blk;
        st[0] = 64'h80400C0600000000;
        st[1] = k[127:64]; st[2] = k[63:0];
        st[3] = n[127:64]; st[4] = n[63:0];
        st = perm(st, 12);
        st[3] ^= k[127:64]; st[4] ^= k[63:0];
        st[0] ^= {a, 8'h80, 24'h0};
        st = perm(st, 6);
        st[4] ^= 64'd1;
        c = '0;
        for (int b = 0; b < NBLK; b++) begin
            blk = p[255 - 64*b -: 64];
            if (b == NBLK - 1) blk = (blk & TAIL_MASK) | 64'h80;
            st[0] ^= blk;
            c[255 - 64*b -: 64] = (b == NBLK - 1) ? (st[0] & TAIL_MASK) : st[0];
            if (b < NBLK - 1) st = perm(st, 6);
        end
        st[1] ^= k[127:64]; st[2] ^= k[63:0];
        st = perm(st, 12);
        t = {st[3] ^ k[127:64], st[4] ^ k[63:0]};
    endtask

    // Drive junk on the handshake inputs during busy cycles.
    task automatic junk(input bit noisy);
        if (noisy) begin
            start    = 1'($urandom % 2);
            pt_valid = 1'($urandom % 2);
            pt_data  = {$urandom, $urandom};
        end
    endtask

    task automatic run_trial(input logic [127:0] k, input logic [127:0] n,
                             input logic [31:0] a, input logic [255:0] p,
                             input bit noisy);
        logic [255:0] exp_c;
        logic [127:0] exp_t;
        logic [63:0]  blk, exp_w;
        int cnt;
        model(k, n, a, p, exp_c, exp_t);
        @(negedge clk);
        key = k; nonce = n; ad_data = a; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        if (noisy) begin   // R8: inputs change after capture
            key = {4{$urandom}}; nonce = {4{$urandom}}; ad_data = $urandom;
        end
        cnt = 0;
        do begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (!pt_req) junk(noisy);
        end while (!pt_req && cnt < 100);
        start = 1'b0; pt_valid = 1'b0;
        check(cnt == 18, "R2 setup latency", 128'(cnt), 128'd18);

        for (int b = 0; b < NBLK; b++) begin
            if (b > 0) begin
                cnt = 0;
                do begin
                    @(posedge clk); cnt++;
                    @(negedge clk);
                    if (!pt_req) junk(noisy);
                end while (!pt_req && cnt < 100);
                start = 1'b0; pt_valid = 1'b0;
                check(cnt == 6, "R5 block spacing", 128'(cnt), 128'd6);
            end
            if (noisy) begin
                repeat ($urandom % 3) begin
                    start = 1'b1;
                    @(posedge clk);
                    @(negedge clk);
                end
                start = 1'b0;
                check(pt_req == 1'b1, "R9 request held", 128'(pt_req), 128'd1);
            end
            blk = p[255 - 64*b -: 64];
            if (b == NBLK - 1 && noisy) blk[7:0] = 8'($urandom);
            pt_data = blk; pt_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            pt_valid = 1'b0;
            exp_w = exp_c[255 - 64*b -: 64];
            check(ct_valid == 1'b1, "R5 ct_valid", 128'(ct_valid), 128'd1);
            check(pt_req == 1'b0, "R5 request drop", 128'(pt_req), 128'd0);
            if (b == 0)
                check(ct_data == exp_w, "R4 first word", 128'(ct_data), 128'(exp_w));
            else if (b == NBLK - 1)
                check(ct_data == exp_w, "R6 tail word", 128'(ct_data), 128'(exp_w));
            else
                check(ct_data == exp_w, "R3 ciphertext", 128'(ct_data), 128'(exp_w));
            check(ct_keep == ((b == NBLK - 1) ? TAIL_KEEP : 8'hFF), "R6 keep",
                  128'(ct_keep), 128'((b == NBLK - 1) ? TAIL_KEEP : 8'hFF));
            got_ct[b] = ct_data;
        end

        cnt = 0;
        do begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (!done) junk(noisy);
        end while (!done && cnt < 100);
        start = 1'b0; pt_valid = 1'b0;
        check(cnt == 12, "R7 tag latency", 128'(cnt), 128'd12);
        check(tag == exp_t, "R7 tag", tag, exp_t);
        got_tag = tag;
        repeat (3) begin
            pt_valid = noisy;
            pt_data  = {$urandom, $urandom};
            @(posedge clk);
            @(negedge clk);
        end
        pt_valid = 1'b0;
        check(done && tag == exp_t, "R7 result held", tag, exp_t);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] kat_k, kat_n;
        logic [255:0] kat_p;
        void'($urandom(32'd1357));
        start = 1'b1; pt_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!done && !ct_valid && !pt_req, "R1 during reset",
              {ct_valid, pt_req, done}, 128'd0);
        rst_n = 1'b1; start = 1'b0; pt_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!done && !ct_valid && !pt_req, "R1 after reset",
              {ct_valid, pt_req, done}, 128'd0);

        kat_k = 128'h000102030405060708090A0B0C0D0E0F;
        kat_n = 128'h00112233445566778899AABBCCDDEEFF;
        kat_p = {64'h436F6E636576657A, 64'h204153434F4E2065,
                 64'h6E2053797374656D, 64'h566572696C6F6700};
        for (int pass = 0; pass < 2; pass++) begin
            run_trial(kat_k, kat_n, 32'h32303233, kat_p, pass == 1);
            check(got_ct[0] == 64'h0567b46d138a8b5f, "R10 word 0", 128'(got_ct[0]), 128'h0567b46d138a8b5f);
            check(got_ct[1] == 64'hdb5cba9823530f3f, "R10 word 1", 128'(got_ct[1]), 128'hdb5cba9823530f3f);
            check(got_ct[2] == 64'h3339ce01a4e4b32f, "R10 word 2", 128'(got_ct[2]), 128'h3339ce01a4e4b32f);
            check(got_ct[3] == 64'h1fc9a149abfd3a00, "R10 word 3", 128'(got_ct[3]), 128'h1fc9a149abfd3a00);
            check(got_tag == 128'hC5EB902A13307077470039BC3A6928EC, "R10 tag",
                  got_tag, 128'hC5EB902A13307077470039BC3A6928EC);
        end

        for (int i = 0; i < 24; i++) begin
            run_trial({4{$urandom}}, {4{$urandom}}, $urandom,
                      {8{$urandom}}, (i % 2) == 1);
        end
        // Corner patterns: all-zero and all-one inputs.
        run_trial('0, '0, '0, '0, 1'b0);
        run_trial('1, '1, '1, '1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule